// File: doc/BRIEF.md
# Oscillator Stop and Warm-up Status Counter

This block gates a main crystal oscillator and measures how long it has been running since it last started. Software reaches it through a byte-wide register bus with per-bit write masks. A control byte holds one meaningful field, a stop flag. The oscillator is shut down by that flag, by a stop request from the subsystem-clock path, or by entry into the chip's STOP mode. A read-only status byte reports warm-up progress as a sticky thermometer code. Each bit marks one elapsed threshold of oscillator cycles.

Oscillator cycles arrive as a qualifying pulse `osc_tick` in the block's clock domain. A 17-bit counter accumulates them while the oscillator is enabled. It saturates at the last threshold, so the code never wraps. Any shutdown cause zeroes the counter and the code. Counting starts again from zero once the oscillator is enabled again.

The core is a three-state machine:
- **OSC_OFF**: the oscillator is disabled and the counter is held at zero.
- **OSC_WARM**: the oscillator is enabled and the counter advances on each tick.
- **OSC_STABLE**: the counter has saturated and every status bit is set.

Transitions:
- **T_HALT**: any state goes to OSC_OFF when a shutdown cause is present.
- **T_START**: OSC_OFF goes to OSC_WARM when no cause remains.
- **T_SAT**: OSC_WARM goes to OSC_STABLE on the tick that brings the count to 2^16.

Reset enters OSC_WARM with a zero count.

Top module: `osc_stab_ctrl`

## Requirements
- R1: After reset, the control byte (address 0xA2) reads 0x00, the status byte (address 0xA3) reads 0x00, and `osc_en` is 1.
- R2: Control byte bit 7 is the stop flag. Bits 6..0 always read 0. A write changes the flag only when `bus_wmask[7]` is 1.
- R3: Writing the stop flag to 1 takes effect only while `ring_sel` is 1. With `ring_sel` 0, such a write leaves the flag at 0, `osc_en` at 1 and the status unchanged. Writing the flag to 0 is always accepted.
- R4: `osc_en` goes to 0 on the clock edge that samples the stop flag, `sub_stop_req` or `stop_mode` high. It stays 0 while any of them is high.
- R5: The status byte is read-only, and bus writes to 0xA3 do not change it.
- R6: Status bit 4 sets after 2^11 counted ticks, bit 3 after 2^13, bit 2 after 2^14, bit 1 after 2^15 and bit 0 after 2^16. Bits 7..5 read 0. Each bit changes on the edge that counts the threshold tick.
- R7: Status bits stay set while the oscillator runs. After 2^16 ticks the code stays 0x1F however many more ticks arrive.
- R8: The status byte becomes 0x00 on the edge that samples any shutdown cause (stop flag, `sub_stop_req`, `stop_mode`). It stays 0x00 while the cause persists.
- R9: When the last shutdown cause is removed, `osc_en` returns to 1 one edge later. Counting restarts from zero, so bit 4 sets again exactly 2^11 ticks after that.
- R10: Only clock cycles with `osc_tick` high advance the count.
- R11: Reads from any address other than 0xA2 and 0xA3 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_wmask | input | 8 | Per-bit write enable |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ring_sel | input | 1 | 1 while the CPU runs from the internal ring oscillator |
| sub_stop_req | input | 1 | Oscillator stop request from the subsystem-clock path |
| stop_mode | input | 1 | High while the chip is in STOP mode |
| osc_tick | input | 1 | One pulse per main-oscillator cycle |
| osc_en | output | 1 | Main oscillator enable |

## Verification
The assertions assume that the shutdown inputs and `ring_sel` are synchronous to `clk` and change only between edges. They also assume that `osc_tick` carries at most one oscillator cycle per clock. The stimulus changes every input on the falling edge and gives at most one tick per cycle. It also keeps `ring_sel` steady across each write, so the stop-flag gating and the sticky-code properties see well-defined values at every edge.

// File: rtl/osc_stab_pkg.sv
package osc_stab_pkg;

    typedef enum logic [1:0] {
        OSC_OFF    = 2'd0,
        OSC_WARM   = 2'd1,
        OSC_STABLE = 2'd2
    } osc_state_t;

    localparam int unsigned NUM_THR = 5;

endpackage

// File: rtl/osc_ctrl_reg.sv
module osc_ctrl_reg #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 8,
    parameter logic [7:0]  CTRL_ADDR = 8'hA2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_wmask,
    input  logic              ring_sel,
    output logic              stop_flag
);

    localparam int unsigned STOP_BIT = DATA_W - 1;

    logic hit;
    assign hit = bus_wr && (bus_addr == CTRL_ADDR[ADDR_W-1:0]) && bus_wmask[STOP_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_flag <= 1'b0;
        end else if (hit) begin
            if (!bus_wdata[STOP_BIT])
                stop_flag <= 1'b0;
            else if (ring_sel)
                stop_flag <= 1'b1;
        end
    end

    AST_STOP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_sel && !stop_flag) |=> !stop_flag); // R3

endmodule

// File: rtl/osc_stab_fsm.sv
module osc_stab_fsm
    import osc_stab_pkg::*;
#(
    parameter int unsigned THR_EXP [NUM_THR] = '{11, 13, 14, 15, 16}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt,
    input  logic               tick,
    output logic               osc_en,
    output logic [NUM_THR-1:0] status
);

    localparam int unsigned CNT_W = THR_EXP[NUM_THR-1] + 1;
    localparam logic [CNT_W-1:0] SAT = CNT_W'(1) << THR_EXP[NUM_THR-1];

    osc_state_t state, state_nx;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            OSC_OFF:    if (!halt) state_nx = OSC_WARM;
            OSC_WARM:   if (halt) state_nx = OSC_OFF;
                        else if (tick && cnt == SAT - 1'b1) state_nx = OSC_STABLE;
            OSC_STABLE: if (halt) state_nx = OSC_OFF;
            default:    state_nx = OSC_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OSC_WARM;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (halt || state == OSC_OFF)
            cnt <= '0;
        else if (state == OSC_WARM && tick)
            cnt <= cnt + 1'b1;
    end

    always_comb begin
        osc_en = (state != OSC_OFF);
    end

    for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
        assign status[NUM_THR-1-i] = (cnt >= (CNT_W'(1) << THR_EXP[i]));
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= SAT); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !halt |=> ((status & $past(status)) == $past(status))); // R7
    AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (status == '0 && !osc_en)); // R8
    AST_THERMO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        status inside {5'b00000, 5'b10000, 5'b11000, 5'b11100, 5'b11110, 5'b11111}); // R6
    AST_STABLE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OSC_STABLE) |-> (status == '1)); // R7

endmodule

// File: rtl/osc_stab_ctrl.sv
module osc_stab_ctrl
    import osc_stab_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 8,
    parameter logic [7:0]  CTRL_ADDR = 8'hA2,
    parameter logic [7:0]  STAT_ADDR = 8'hA3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_wmask,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ring_sel,
    input  logic              sub_stop_req,
    input  logic              stop_mode,
    input  logic              osc_tick,
    output logic              osc_en
);

    logic               stop_flag;
    logic               halt;
    logic [NUM_THR-1:0] status;

    osc_ctrl_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_wmask(bus_wmask), .ring_sel(ring_sel),
        .stop_flag(stop_flag)
    );

    assign halt = stop_flag | sub_stop_req | stop_mode;

    osc_stab_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .halt(halt), .tick(osc_tick),
        .osc_en(osc_en), .status(status)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR[ADDR_W-1:0])
            bus_rdata[DATA_W-1] = stop_flag;
        else if (bus_addr == STAT_ADDR[ADDR_W-1:0])
            bus_rdata[NUM_THR-1:0] = status;
    end

    always_comb begin
        if (rst_n && bus_addr == CTRL_ADDR[ADDR_W-1:0])
            AST_CTRL_LOW_ZERO: assert (bus_rdata[DATA_W-2:0] == '0); // R2
    end

    AST_EN_FOLLOWS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        !halt |=> osc_en); // R9

endmodule

// File: tb/sim_osc_stab_ctrl.sv
`timescale 1ns/1ps
module sim_osc_stab_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_wmask = 8'h00;
    logic [7:0] bus_rdata;
    logic       ring_sel = 1'b0;
    logic       sub_stop_req = 1'b0;
    logic       stop_mode = 1'b0;
    logic       osc_tick = 1'b0;
    logic       osc_en;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    osc_stab_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_wmask(bus_wmask), .bus_rdata(bus_rdata),
        .ring_sel(ring_sel), .sub_stop_req(sub_stop_req), .stop_mode(stop_mode),
        .osc_tick(osc_tick), .osc_en(osc_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [7:0] m);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wmask = m; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wmask = 8'h00;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        osc_tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        osc_tick = 1'b0;
    endtask

    task automatic chk_stat(input string req, input logic [7:0] exp);
        logic [7:0] d;
        rd(8'hA3, d);
        check(req, d, exp);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        @(negedge clk);
        rd(8'hA2, d); check("R1 ctrl", d, 8'h00);
        chk_stat("R1 status", 8'h00);
        check("R1 osc_en", {7'd0, osc_en}, 8'h01);
    endtask

    task automatic t_tick_gate;
        repeat (3000) @(negedge clk);
        chk_stat("R10 no ticks", 8'h00);
    endtask

    task automatic t_thresholds;
        ticks(2047);  chk_stat("R6 2047", 8'h00);
        ticks(1);     chk_stat("R6 2^11", 8'h10);
        ticks(6143);  chk_stat("R6 8191", 8'h10);
        ticks(1);     chk_stat("R6 2^13", 8'h18);
        ticks(8191);  chk_stat("R6 16383", 8'h18);
        ticks(1);     chk_stat("R6 2^14", 8'h1C);
        ticks(16384); chk_stat("R6 2^15", 8'h1E);
        ticks(32767); chk_stat("R6 65535", 8'h1E);
        ticks(1);     chk_stat("R6 2^16", 8'h1F);
        ticks(500);   chk_stat("R7 saturate", 8'h1F);
    endtask

    task automatic t_status_ro;
        wr(8'hA3, 8'h00, 8'hFF);
        chk_stat("R5 ro", 8'h1F);
    endtask

    task automatic t_stop_gate;
        logic [7:0] d;
        ring_sel = 1'b0;
        wr(8'hA2, 8'h80, 8'h80);
        @(negedge clk);
        rd(8'hA2, d); check("R3 flag ignored", d, 8'h00);
        check("R3 osc_en", {7'd0, osc_en}, 8'h01);
        chk_stat("R3 status kept", 8'h1F);
    endtask

    task automatic t_ctrl_and_stop;
        logic [7:0] d;
        ring_sel = 1'b1;
        wr(8'hA2, 8'h7F, 8'h7F);
        rd(8'hA2, d); check("R2 low bits", d, 8'h00);
        wr(8'hA2, 8'h80, 8'h7F);
        rd(8'hA2, d); check("R2 mask", d, 8'h00);
        check("R2 osc_en", {7'd0, osc_en}, 8'h01);
        wr(8'hA2, 8'h80, 8'h80);
        rd(8'hA2, d); check("R2 flag set", d, 8'h80);
        @(negedge clk);
        check("R4 stop flag", {7'd0, osc_en}, 8'h00);
        chk_stat("R8 stop flag clear", 8'h00);
        ticks(3000);
        chk_stat("R8 held", 8'h00);
        rd(8'h55, d); check("R11 other addr", d, 8'h00);
        ring_sel = 1'b0;
        wr(8'hA2, 8'h00, 8'hFF);
        rd(8'hA2, d); check("R3 clear allowed", d, 8'h00);
        @(negedge clk);
        check("R9 osc_en back", {7'd0, osc_en}, 8'h01);
        ticks(2047); chk_stat("R9 2047", 8'h00);
        ticks(1);    chk_stat("R9 2^11", 8'h10);
    endtask

    task automatic t_other_clears;
        @(negedge clk); sub_stop_req = 1'b1;
        @(negedge clk);
        check("R4 sub_stop", {7'd0, osc_en}, 8'h00);
        chk_stat("R8 sub_stop", 8'h00);
        sub_stop_req = 1'b0;
        @(negedge clk);
        check("R9 after sub_stop", {7'd0, osc_en}, 8'h01);
        ticks(2048); chk_stat("R9 recount", 8'h10);
        @(negedge clk); stop_mode = 1'b1;
        @(negedge clk);
        check("R4 stop_mode", {7'd0, osc_en}, 8'h00);
        chk_stat("R8 stop_mode", 8'h00);
        stop_mode = 1'b0;
        @(negedge clk);
        ticks(2048); chk_stat("R9 after stop_mode", 8'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tick_gate();
        t_thresholds();
        t_status_ro();
        t_stop_gate();
        t_ctrl_and_stop();
        t_other_clears();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait (cyc >= 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule